// File: doc/BRIEF.md
# Serial Frame Start Condition Detector

This block decides the moment at which one direction of a synchronous serial port (receive or transmit) begins a data transfer. It watches a frame-sync input line, a start request coming from the opposite direction, a flag saying that a word waits in the holding register, a "previous data finished" pulse and a compare-match on received data. A 4-bit start-mode input selects which of these conditions opens a transfer.

When the selected condition is seen, the block counts a programmable number of bit clocks. It then issues a one-cycle start pulse to the shift engine. Independently of the start mode, it flags a sync-detected event on the frame-sync edge chosen by an edge-select input.

The same module serves both directions. A parameter marks the receive instance, which alone honours the compare-match mode and does not wait for a holding word.

Top module: `frame_start_detector`

## Requirements
- R1: After reset, `start_pulse` and `sync_evt` are low.
- R2: For a start delay D, `start_pulse` is high for exactly one clock. That clock follows the (D+1)-th `bit_tick` after the condition was detected, so D=0 starts on the first bit tick after detection.
- R3: Mode 0x0 (continuous) starts once when the direction becomes enabled, and again after each `xfer_done` pulse. With RX_SIDE=0 it waits until `word_avail` is high.
- R4: Mode 0x1 starts when `peer_start` pulses, and never without it.
- R5: Mode 0x2 starts while the synchronized frame-sync line is low, and mode 0x3 while it is high.
- R6: Mode 0x4 starts only on a falling edge of the frame-sync line, and mode 0x5 only on a rising edge.
- R7: Mode 0x7 starts on any transition of the line. Mode 0x6 starts whenever the line level differs from the level recorded at the previous detection (or at enable time). A single change during the delay therefore re-triggers mode 0x6 once the delay has run out, but not mode 0x7.
- R8: Mode 0x8 starts when `rx_word_valid` is high and `rx_word` equals `cmp_value`, only with RX_SIDE=1. With RX_SIDE=0, mode 0x8 never starts.
- R9: Mode values 0x9 to 0xF never produce a start.
- R10: A condition that arrives while the delay is counting is ignored.
- R11: Driving `dir_en` low or pulsing `soft_rst` clears a pending delay, and no start follows from it.
- R12: With `dir_en` high, `sync_evt` pulses for one clock, three clocks after `sync_in` changes. It fires on a rising change when `sync_edge_sel`=0 and on a falling change when `sync_edge_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Software reset pulse, cancels pending start |
| dir_en | input | 1 | Direction enabled |
| bit_tick | input | 1 | One-cycle strobe per bit clock |
| start_mode | input | 4 | Start condition select |
| start_delay | input | 8 | Bit clocks to wait after detection |
| sync_in | input | 1 | Asynchronous frame-sync line |
| sync_edge_sel | input | 1 | 0: rising, 1: falling edge for sync event |
| peer_start | input | 1 | Start pulse of the opposite direction |
| word_avail | input | 1 | Holding word present (transmit side) |
| xfer_done | input | 1 | Previous data transfer finished |
| rx_word | input | 16 | Received data for compare |
| rx_word_valid | input | 1 | `rx_word` is valid this clock |
| cmp_value | input | 16 | Compare value for mode 0x8 |
| start_pulse | output | 1 | One-cycle transfer start |
| sync_evt | output | 1 | One-cycle sync-detected event |

## Verification
A counter that loads or decrements wrongly shows up as a start pulse one or more bit ticks early or late. The bench issues bit ticks one at a time and checks the pulse after every single tick, so such an error appears on the first tick that differs. A detection gate that stays open during the delay, or a reference level that is not kept, shows up as an extra pulse or a missing pulse within two ticks of the previous start. A synchronizer of the wrong depth moves `sync_evt` by a clock, and this is caught at the exact sampling clock.

// File: rtl/fsd_pkg.sv
// Shared constants and types for the frame start detector.
// Assumes a 4-bit start-mode code; values above MODE_MATCH are reserved.
package fsd_pkg;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_CONT   = 4'h0;
    localparam logic [MODE_W-1:0] MODE_PEER   = 4'h1;
    localparam logic [MODE_W-1:0] MODE_LOW    = 4'h2;
    localparam logic [MODE_W-1:0] MODE_HIGH   = 4'h3;
    localparam logic [MODE_W-1:0] MODE_FALL   = 4'h4;
    localparam logic [MODE_W-1:0] MODE_RISE   = 4'h5;
    localparam logic [MODE_W-1:0] MODE_CHANGE = 4'h6;
    localparam logic [MODE_W-1:0] MODE_EDGE   = 4'h7;
    localparam logic [MODE_W-1:0] MODE_MATCH  = 4'h8;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_WAIT = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } sync_view_t;
endpackage

// File: rtl/fsd_sync_edge.sv
// Synchronizes the frame-sync line and derives rise/fall strobes.
// Assumes STAGES >= 2; the strobes last one clock each.
module fsd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_in,
    output fsd_pkg::sync_view_t view
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], sync_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Compare the settled sample against the previous one.
    always_comb begin
        view.level = sync_q[STAGES-1];
        view.rise  = sync_q[STAGES-1] & ~prev_q;
        view.fall  = ~sync_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/fsd_start_select.sv
// Evaluates the selected start condition while the delay timer is idle.
// Assumes conditions are only taken when enabled, not in soft reset, and idle.
// RX_SIDE enables the compare mode and drops the holding-word requirement.
module fsd_start_select #(
    parameter int RX_SIDE = 1,
    parameter int CMP_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dir_en,
    input  logic                     soft_rst,
    input  logic                     idle,
    input  logic [fsd_pkg::MODE_W-1:0] mode,
    input  fsd_pkg::sync_view_t      view,
    input  logic                     peer_start,
    input  logic                     word_avail,
    input  logic                     xfer_done,
    input  logic [CMP_W-1:0]         rx_word,
    input  logic                     rx_word_valid,
    input  logic [CMP_W-1:0]         cmp_value,
    output logic                     cond_hit
);
    import fsd_pkg::*;

    localparam bit HAS_MATCH = (RX_SIDE != 0);

    logic en_q;
    logic cont_req;
    logic ref_level;
    logic allowed;
    logic word_ok;
    logic match_ok;
    logic raw_hit;

    // Gate detection to enabled, non-reset, idle cycles.
    always_comb begin
        allowed  = dir_en & ~soft_rst & idle;
        word_ok  = HAS_MATCH | word_avail;
        match_ok = HAS_MATCH & rx_word_valid & (rx_word == cmp_value);
    end

    // Decode the start mode into a raw condition.
    always_comb begin
        unique case (mode)
            MODE_CONT:   raw_hit = cont_req & word_ok;
            MODE_PEER:   raw_hit = peer_start;
            MODE_LOW:    raw_hit = ~view.level;
            MODE_HIGH:   raw_hit = view.level;
            MODE_FALL:   raw_hit = view.fall;
            MODE_RISE:   raw_hit = view.rise;
            MODE_CHANGE: raw_hit = view.level ^ ref_level;
            MODE_EDGE:   raw_hit = view.rise | view.fall;
            MODE_MATCH:  raw_hit = match_ok;
            default:     raw_hit = 1'b0;
        endcase
        cond_hit = allowed & raw_hit;
    end

    // Track continuous-start requests and the reference level of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            cont_req  <= 1'b0;
            ref_level <= 1'b0;
        end else if (soft_rst || !dir_en) begin
            en_q      <= 1'b0;
            cont_req  <= 1'b0;
            ref_level <= view.level;
        end else begin
            en_q <= 1'b1;
            if (!en_q || xfer_done) begin
                cont_req <= 1'b1;
            end else if (cond_hit) begin
                cont_req <= 1'b0;
            end
            if (cond_hit) begin
                ref_level <= view.level;
            end
        end
    end
endmodule

// File: rtl/fsd_delay_timer.sv
// Counts the start delay in bit ticks and emits the registered start pulse.
// Assumes cond_hit arrives only while idle; clear aborts a pending start.
module fsd_delay_timer #(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               cond_hit,
    input  logic [DELAY_W-1:0] delay,
    input  logic               bit_tick,
    output logic               idle,
    output logic               start_pulse
);
    import fsd_pkg::*;

    tmr_state_e         state_q;
    logic [DELAY_W-1:0] cnt_q;

    // Load on detection, count ticks, fire when the count is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= TMR_IDLE;
            cnt_q       <= '0;
            start_pulse <= 1'b0;
        end else if (clear) begin
            state_q     <= TMR_IDLE;
            cnt_q       <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            unique case (state_q)
                TMR_IDLE: begin
                    if (cond_hit) begin
                        cnt_q   <= delay;
                        state_q <= TMR_WAIT;
                    end
                end
                TMR_WAIT: begin
                    if (bit_tick) begin
                        if (cnt_q == '0) begin
                            start_pulse <= 1'b1;
                            state_q     <= TMR_IDLE;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                default: state_q <= TMR_IDLE;
            endcase
        end
    end

    // Expose the idle state to the condition selector.
    always_comb idle = (state_q == TMR_IDLE);
endmodule

// File: rtl/frame_start_detector.sv
// Top of the frame start detector: synchronizer, condition select, delay.
// Assumes bit_tick is a one-clock strobe in the clk domain.
module frame_start_detector #(
    parameter int RX_SIDE     = 1,
    parameter int DELAY_W     = 8,
    parameter int CMP_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic                       dir_en,
    input  logic                       bit_tick,
    input  logic [fsd_pkg::MODE_W-1:0] start_mode,
    input  logic [DELAY_W-1:0]         start_delay,
    input  logic                       sync_in,
    input  logic                       sync_edge_sel,
    input  logic                       peer_start,
    input  logic                       word_avail,
    input  logic                       xfer_done,
    input  logic [CMP_W-1:0]           rx_word,
    input  logic                       rx_word_valid,
    input  logic [CMP_W-1:0]           cmp_value,
    output logic                       start_pulse,
    output logic                       sync_evt
);
    fsd_pkg::sync_view_t view;
    logic                cond_hit;
    logic                tmr_idle;
    logic                tmr_clear;

    // Cancel pending work on disable or software reset.
    always_comb tmr_clear = soft_rst | ~dir_en;

    fsd_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .view    (view)
    );

    fsd_start_select #(
        .RX_SIDE (RX_SIDE),
        .CMP_W   (CMP_W)
    ) u_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .dir_en        (dir_en),
        .soft_rst      (soft_rst),
        .idle          (tmr_idle),
        .mode          (start_mode),
        .view          (view),
        .peer_start    (peer_start),
        .word_avail    (word_avail),
        .xfer_done     (xfer_done),
        .rx_word       (rx_word),
        .rx_word_valid (rx_word_valid),
        .cmp_value     (cmp_value),
        .cond_hit      (cond_hit)
    );

    fsd_delay_timer #(
        .DELAY_W (DELAY_W)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (tmr_clear),
        .cond_hit    (cond_hit),
        .delay       (start_delay),
        .bit_tick    (bit_tick),
        .idle        (tmr_idle),
        .start_pulse (start_pulse)
    );

    // Register the sync-detected event on the chosen edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_evt <= 1'b0;
        end else begin
            sync_evt <= dir_en & (sync_edge_sel ? view.fall : view.rise);
        end
    end
endmodule

// File: rtl/fsd_checks.sv
// Property checker for frame_start_detector, attached by bind.
module fsd_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       dir_en,
    input logic       bit_tick,
    input logic [3:0] start_mode,
    input logic       cond_hit,
    input logic       tmr_idle,
    input logic       start_pulse,
    input logic       sync_evt
);
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    a_r2_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(bit_tick));

    a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_en || soft_rst) |=> !start_pulse);

    a_r9_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (start_mode > 4'd8) |-> !cond_hit);

    a_r10_no_hit_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_idle |-> !cond_hit);

    a_r12_evt_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |-> $past(dir_en));
endmodule

bind frame_start_detector fsd_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .dir_en      (dir_en),
    .bit_tick    (bit_tick),
    .start_mode  (start_mode),
    .cond_hit    (cond_hit),
    .tmr_idle    (tmr_idle),
    .start_pulse (start_pulse),
    .sync_evt    (sync_evt)
);

// File: tb/sim_frame_start_detector.sv
module sim_frame_start_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        dir_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic [3:0]  start_mode = 4'h9;
    logic [7:0]  start_delay = 8'd0;
    logic        sync_in = 1'b0;
    logic        sync_edge_sel = 1'b0;
    logic        peer_start = 1'b0;
    logic        word_avail = 1'b1;
    logic        xfer_done = 1'b0;
    logic [15:0] rx_word = 16'h0;
    logic        rx_word_valid = 1'b0;
    logic [15:0] cmp_value = 16'h4321;
    logic        sp0, sp1, ev0, ev1;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    frame_start_detector #(.RX_SIDE(1)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dir_en(dir_en),
        .bit_tick(bit_tick), .start_mode(start_mode), .start_delay(start_delay),
        .sync_in(sync_in), .sync_edge_sel(sync_edge_sel), .peer_start(peer_start),
        .word_avail(word_avail), .xfer_done(xfer_done), .rx_word(rx_word),
        .rx_word_valid(rx_word_valid), .cmp_value(cmp_value),
        .start_pulse(sp0), .sync_evt(ev0));

    frame_start_detector #(.RX_SIDE(0)) u1 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dir_en(dir_en),
        .bit_tick(bit_tick), .start_mode(start_mode), .start_delay(start_delay),
        .sync_in(sync_in), .sync_edge_sel(sync_edge_sel), .peer_start(peer_start),
        .word_avail(word_avail), .xfer_done(xfer_done), .rx_word(rx_word),
        .rx_word_valid(rx_word_valid), .cmp_value(cmp_value),
        .start_pulse(sp1), .sync_evt(ev1));

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // One bit tick; start pulse is visible at the next falling edge.
    task automatic tick_expect(input logic e0, input logic e1, input string tag);
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
        check(sp0, e0, {tag, " rx"});
        check(sp1, e1, {tag, " tx"});
    endtask

    task automatic prep(input logic [3:0] mode, input logic [7:0] dly);
        @(negedge clk); dir_en = 1'b0;
        start_mode = mode; start_delay = dly;
        wait_clk(4);
        dir_en = 1'b1;
        wait_clk(4);
    endtask

    task automatic t_reset();
        check(sp0, 1'b0, "R1 start after reset");
        check(ev0, 1'b0, "R1 event after reset");
        check(sp1, 1'b0, "R1 tx start after reset");
    endtask

    task automatic t_continuous();
        @(negedge clk); dir_en = 1'b0; word_avail = 1'b0;
        start_mode = 4'h0; start_delay = 8'd0;
        wait_clk(4); dir_en = 1'b1; wait_clk(4);
        tick_expect(1'b1, 1'b0, "R3 enable start, tx waits for word");
        word_avail = 1'b1; wait_clk(3);
        tick_expect(1'b0, 1'b1, "R3 tx starts once word present");
        tick_expect(1'b0, 1'b0, "R3 no restart without done");
        pulse(xfer_done); wait_clk(3);
        tick_expect(1'b1, 1'b1, "R3 restart after done");
    endtask

    task automatic t_peer();
        prep(4'h1, 8'd2);
        tick_expect(1'b0, 1'b0, "R4 idle without peer");
        pulse(peer_start); wait_clk(3);
        tick_expect(1'b0, 1'b0, "R2 delay tick 1");
        tick_expect(1'b0, 1'b0, "R2 delay tick 2");
        tick_expect(1'b1, 1'b1, "R4 R2 start on third tick");
        tick_expect(1'b0, 1'b0, "R2 single start");
    endtask

    task automatic t_levels();
        sync_in = 1'b0; prep(4'h2, 8'd0);
        tick_expect(1'b1, 1'b1, "R5 low level starts");
        sync_in = 1'b0; prep(4'h3, 8'd0);
        tick_expect(1'b0, 1'b0, "R5 high mode quiet on low");
        sync_in = 1'b1; wait_clk(5);
        tick_expect(1'b1, 1'b1, "R5 high level starts");
        @(negedge clk); sync_in = 1'b0; wait_clk(4);
    endtask

    task automatic t_edges();
        sync_in = 1'b0; prep(4'h5, 8'd0);
        tick_expect(1'b0, 1'b0, "R6 rise mode idle");
        sync_in = 1'b1; wait_clk(5);
        tick_expect(1'b1, 1'b1, "R6 rising edge starts");
        sync_in = 1'b0; wait_clk(5);
        tick_expect(1'b0, 1'b0, "R6 falling ignored in rise mode");
        prep(4'h4, 8'd0);
        sync_in = 1'b1; wait_clk(5);
        tick_expect(1'b0, 1'b0, "R6 rising ignored in fall mode");
        sync_in = 1'b0; wait_clk(5);
        tick_expect(1'b1, 1'b1, "R6 falling edge starts");
    endtask

    task automatic t_change_vs_edge();
        sync_in = 1'b0; prep(4'h6, 8'd1);
        tick_expect(1'b0, 1'b0, "R7 change mode steady");
        sync_in = 1'b1; wait_clk(5);
        sync_in = 1'b0; wait_clk(5);
        tick_expect(1'b0, 1'b0, "R7 change delay tick");
        tick_expect(1'b1, 1'b1, "R7 change start");
        wait_clk(3);
        tick_expect(1'b0, 1'b0, "R7 change retrigger delay");
        tick_expect(1'b1, 1'b1, "R7 change retriggers on differing level");
        tick_expect(1'b0, 1'b0, "R7 change settles");
        tick_expect(1'b0, 1'b0, "R7 change settled");
        sync_in = 1'b0; prep(4'h7, 8'd1);
        sync_in = 1'b1; wait_clk(5);
        sync_in = 1'b0; wait_clk(5);
        tick_expect(1'b0, 1'b0, "R7 edge delay tick");
        tick_expect(1'b1, 1'b1, "R7 edge start");
        wait_clk(3);
        tick_expect(1'b0, 1'b0, "R10 edge during delay ignored");
        tick_expect(1'b0, 1'b0, "R10 edge during delay still ignored");
    endtask

    task automatic t_match();
        prep(4'h8, 8'd0);
        rx_word = 16'h1234; pulse(rx_word_valid); wait_clk(3);
        tick_expect(1'b0, 1'b0, "R8 mismatch no start");
        rx_word = 16'h4321; pulse(rx_word_valid); wait_clk(3);
        tick_expect(1'b1, 1'b0, "R8 match starts rx only");
    endtask

    task automatic t_reserved();
        for (int m = 9; m < 16; m++) begin
            sync_in = 1'b0; prep(4'(m), 8'd0);
            sync_in = 1'b1;
            pulse(peer_start); pulse(xfer_done);
            rx_word = cmp_value; pulse(rx_word_valid);
            wait_clk(4);
            tick_expect(1'b0, 1'b0, "R9 reserved mode silent");
            sync_in = 1'b0; wait_clk(5);
            tick_expect(1'b0, 1'b0, "R9 reserved mode silent on fall");
        end
    endtask

    task automatic t_cancel();
        prep(4'h1, 8'd3);
        pulse(peer_start); wait_clk(3);
        tick_expect(1'b0, 1'b0, "R11 pending");
        pulse(dir_en); // drives high; set low first below
        @(negedge clk); dir_en = 1'b0;
        @(negedge clk); dir_en = 1'b1; wait_clk(3);
        for (int i = 0; i < 5; i++) tick_expect(1'b0, 1'b0, "R11 disable cancels");
        pulse(peer_start); wait_clk(3);
        tick_expect(1'b0, 1'b0, "R11 pending again");
        pulse(soft_rst); wait_clk(3);
        for (int i = 0; i < 5; i++) tick_expect(1'b0, 1'b0, "R11 soft reset cancels");
        pulse(peer_start); wait_clk(3);
        for (int i = 0; i < 3; i++) tick_expect(1'b0, 1'b0, "R2 delay three counting");
        tick_expect(1'b1, 1'b1, "R2 delay three start");
    endtask

    task automatic t_sync_evt();
        sync_in = 1'b0; sync_edge_sel = 1'b0; prep(4'h9, 8'd0);
        @(negedge clk); sync_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ev0, 1'b1, "R12 rising event timing");
        check(ev1, 1'b1, "R12 rising event timing tx");
        @(negedge clk);
        check(ev0, 1'b0, "R12 event one clock");
        sync_in = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(ev0, 1'b0, "R12 falling ignored with select 0");
        end
        sync_edge_sel = 1'b1; sync_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(ev0, 1'b0, "R12 rising ignored with select 1");
        end
        sync_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ev0, 1'b1, "R12 falling event timing");
        @(negedge clk);
        check(ev0, 1'b0, "R12 falling event one clock");
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_continuous();
        t_peer();
        t_levels();
        t_edges();
        t_change_vs_edge();
        t_match();
        t_reserved();
        t_cancel();
        t_sync_evt();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule